// File: doc/BRIEF.md
# Renaming Reservation Stations with Tag Broadcast

This block sits between in-order instruction issue and a pair of arithmetic pipelines. It holds a small pool of waiting stations split into two classes: adder and multiplier. It also owns the architectural register file and a per-register table naming the station that will next write each register. When an operation is issued, each of its two source registers is turned into either a concrete value or the number of the station that will produce it. The destination register is then marked as owned by the newly allocated station. Because every later reader refers to that station number and never to the register name, write-after-read and write-after-write conflicts cause no stalls.

Finished results come back on one shared result bus that carries a station tag and a 64-bit value. Every waiting station compares its two pending tags against the bus and captures the value where they match. The register file takes the value only if its table entry still names that tag. The station that produced the result becomes free again. A station whose two operands are both present is offered on the dispatch port, and the downstream pipelines accept whatever is offered.

Top module: `rs_rename_core`

## Requirements
- R1: After reset all stations are free, no register has a pending writer (`rf_pend` reads 0), register r holds the value r, and `disp_valid` is low.
- R2: A source register with no pending writer is captured as its current register-file value, and that value appears on `disp_a`/`disp_b` when the station is dispatched.
- R3: A source register with a pending writer records that writer's tag, and the station is not dispatched while either operand is still waiting.
- R4: When the result bus carries a tag, every busy station waiting on that tag in either operand takes the bus value and stops waiting.
- R5: A register takes a broadcast value, and its pending tag returns to 0, only when its table entry equals the broadcast tag. Once a later issue has renamed the register, an older result leaves both the value and the tag unchanged.
- R6: Tag 0 means "no producer". The dispatch port offers the lowest-numbered station that is busy, not yet dispatched and has both operands present. Each station is offered exactly once per allocation.
- R7: Class bit 0 selects the adder stations, tags 1 to 3. Class bit 1 selects the multiplier stations, tags 4 and 5. Issue takes the lowest free tag of the requested class, and it raises `iss_stall` without allocating when that class is full, even if the other class has room.
- R8: The station named by a broadcast tag becomes free at that clock edge and can be allocated again in the following cycle.
- R9: If an issue reads a register whose pending tag is on the result bus in the same cycle, the issue takes the bus value directly and does not wait.
- R10: A station that captured a register value keeps it even when a later instruction renames that register and its result is broadcast first.
- R11: An issue whose destination equals a source reads the source before the destination is renamed to the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An operation is presented for issue |
| iss_cls | input | 1 | Station class: 0 adder, 1 multiplier |
| iss_op | input | 3 | Operation code carried to dispatch |
| iss_rd | input | 3 | Destination register |
| iss_rs | input | 3 | First source register |
| iss_rt | input | 3 | Second source register |
| iss_stall | output | 1 | No free station in the requested class |
| iss_tag | output | 4 | Tag allocated to the presented operation (0 if none) |
| disp_valid | output | 1 | A station is offered for execution |
| disp_tag | output | 4 | Tag of the offered station |
| disp_op | output | 3 | Operation code of the offered station |
| disp_a | output | 64 | First operand value |
| disp_b | output | 64 | Second operand value |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | 4 | Tag of the producing station |
| res_data | input | 64 | Result value |
| rf_addr | input | 3 | Register read address |
| rf_data | output | 64 | Register value at `rf_addr` |
| rf_pend | output | 4 | Pending writer tag of register `rf_addr` (0 if none) |

## Verification
The assertions assume that the result bus only names a station that is busy and has already been offered on the dispatch port. They also assume that the pipelines accept every offer in the cycle it is made. The bench respects this: it drives a broadcast for a tag only after it has seen that tag on `disp_tag`, and it never repeats a tag before that station is reissued. The issue side is left unconstrained, because stalls must be handled by the block itself.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic {
        CLS_ADD = 1'b0,
        CLS_MUL = 1'b1
    } rs_cls_e;

    localparam int NO_TAG = 0;
endpackage

// File: rtl/rs_first_set.sv
module rs_first_set #(
    parameter int W  = 4,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rs_operand_src.sv
module rs_operand_src #(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4
) (
    input  logic [DATA_W-1:0] reg_val,
    input  logic [TAG_W-1:0]  reg_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    output logic [DATA_W-1:0] op_val,
    output logic [TAG_W-1:0]  op_tag
);
    always_comb begin
        if (reg_tag == TAG_W'(rs_pkg::NO_TAG)) begin
            op_val = reg_val;
            op_tag = '0;
        end else if (res_valid && (res_tag == reg_tag)) begin
            // producer finishes in this very cycle: take the bus value
            op_val = res_data;
            op_tag = '0;
        end else begin
            op_val = '0;
            op_tag = reg_tag;
        end
    end
endmodule

// File: rtl/rs_rename_core.sv
module rs_rename_core
    import rs_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int TAG_W    = 4,
    parameter int OP_W     = 3,
    parameter int NUM_ADD  = 3,
    parameter int NUM_MUL  = 2,
    parameter int NUM_REGS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        iss_valid,
    input  logic                        iss_cls,
    input  logic [OP_W-1:0]             iss_op,
    input  logic [$clog2(NUM_REGS)-1:0] iss_rd,
    input  logic [$clog2(NUM_REGS)-1:0] iss_rs,
    input  logic [$clog2(NUM_REGS)-1:0] iss_rt,
    output logic                        iss_stall,
    output logic [TAG_W-1:0]            iss_tag,
    output logic                        disp_valid,
    output logic [TAG_W-1:0]            disp_tag,
    output logic [OP_W-1:0]             disp_op,
    output logic [DATA_W-1:0]           disp_a,
    output logic [DATA_W-1:0]           disp_b,
    input  logic                        res_valid,
    input  logic [TAG_W-1:0]            res_tag,
    input  logic [DATA_W-1:0]           res_data,
    input  logic [$clog2(NUM_REGS)-1:0] rf_addr,
    output logic [DATA_W-1:0]           rf_data,
    output logic [TAG_W-1:0]            rf_pend
);
    localparam int NUM_RS = NUM_ADD + NUM_MUL;
    localparam int AIDX_W = (NUM_ADD > 1) ? $clog2(NUM_ADD) : 1;
    localparam int MIDX_W = (NUM_MUL > 1) ? $clog2(NUM_MUL) : 1;
    localparam int RIDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

    typedef struct packed {
        logic              busy;
        logic              sent;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] vj;
        logic [DATA_W-1:0] vk;
        logic [TAG_W-1:0]  qj;
        logic [TAG_W-1:0]  qk;
    } ent_t;

    typedef struct packed {
        ent_t [NUM_RS-1:0]                  ent;
        logic [NUM_REGS-1:0][DATA_W-1:0]    rf;
        logic [NUM_REGS-1:0][TAG_W-1:0]     stat;
    } st_t;

    st_t s_q, s_d;

    logic [NUM_ADD-1:0] add_free;
    logic [NUM_MUL-1:0] mul_free;
    logic [NUM_RS-1:0]  rdy;
    logic               add_found, mul_found, rdy_found;
    logic [AIDX_W-1:0]  add_idx;
    logic [MIDX_W-1:0]  mul_idx;
    logic [RIDX_W-1:0]  rdy_idx;
    logic               cls_found, iss_go;
    logic [TAG_W-1:0]   new_tag;
    logic [RIDX_W-1:0]  slot;
    logic [DATA_W-1:0]  src_j_val, src_k_val;
    logic [TAG_W-1:0]   src_j_tag, src_k_tag;

    // free and ready vectors from current state
    always_comb begin
        for (int i = 0; i < NUM_ADD; i++) begin
            add_free[i] = !s_q.ent[i].busy;
        end
        for (int i = 0; i < NUM_MUL; i++) begin
            mul_free[i] = !s_q.ent[NUM_ADD + i].busy;
        end
        for (int i = 0; i < NUM_RS; i++) begin
            rdy[i] = s_q.ent[i].busy && !s_q.ent[i].sent &&
                     (s_q.ent[i].qj == '0) && (s_q.ent[i].qk == '0);
        end
    end

    rs_first_set #(.W(NUM_ADD), .IW(AIDX_W)) i_add_pick (
        .req(add_free), .found(add_found), .idx(add_idx)
    );
    rs_first_set #(.W(NUM_MUL), .IW(MIDX_W)) i_mul_pick (
        .req(mul_free), .found(mul_found), .idx(mul_idx)
    );
    rs_first_set #(.W(NUM_RS), .IW(RIDX_W)) i_rdy_pick (
        .req(rdy), .found(rdy_found), .idx(rdy_idx)
    );

    rs_operand_src #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_src_j (
        .reg_val(s_q.rf[iss_rs]), .reg_tag(s_q.stat[iss_rs]),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .op_val(src_j_val), .op_tag(src_j_tag)
    );
    rs_operand_src #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_src_k (
        .reg_val(s_q.rf[iss_rt]), .reg_tag(s_q.stat[iss_rt]),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .op_val(src_k_val), .op_tag(src_k_tag)
    );

    // allocation
    always_comb begin
        if (iss_cls == CLS_MUL) begin
            cls_found = mul_found;
            new_tag   = TAG_W'(NUM_ADD) + TAG_W'(mul_idx) + TAG_W'(1);
        end else begin
            cls_found = add_found;
            new_tag   = TAG_W'(add_idx) + TAG_W'(1);
        end
        iss_go    = iss_valid && cls_found;
        iss_stall = iss_valid && !cls_found;
        iss_tag   = iss_go ? new_tag : '0;
        slot      = RIDX_W'(new_tag - TAG_W'(1));
    end

    // next state
    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_RS; i++) begin
            if (s_q.ent[i].busy && res_valid) begin
                if ((s_q.ent[i].qj != '0) && (s_q.ent[i].qj == res_tag)) begin
                    s_d.ent[i].vj = res_data;
                    s_d.ent[i].qj = '0;
                end
                if ((s_q.ent[i].qk != '0) && (s_q.ent[i].qk == res_tag)) begin
                    s_d.ent[i].vk = res_data;
                    s_d.ent[i].qk = '0;
                end
            end
            if (rdy_found && (int'(rdy_idx) == i)) begin
                s_d.ent[i].sent = 1'b1;
            end
            if (res_valid && (res_tag == TAG_W'(i + 1))) begin
                s_d.ent[i].busy = 1'b0;
                s_d.ent[i].sent = 1'b0;
            end
        end
        for (int r = 0; r < NUM_REGS; r++) begin
            if (res_valid && (s_q.stat[r] != '0) && (s_q.stat[r] == res_tag)) begin
                s_d.rf[r]   = res_data;
                s_d.stat[r] = '0;
            end
        end
        if (iss_go) begin
            s_d.ent[slot].busy = 1'b1;
            s_d.ent[slot].sent = 1'b0;
            s_d.ent[slot].op   = iss_op;
            s_d.ent[slot].vj   = src_j_val;
            s_d.ent[slot].qj   = src_j_tag;
            s_d.ent[slot].vk   = src_k_val;
            s_d.ent[slot].qk   = src_k_tag;
            s_d.stat[iss_rd]   = new_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ent  <= '0;
            s_q.stat <= '0;
            for (int r = 0; r < NUM_REGS; r++) begin
                s_q.rf[r] <= DATA_W'(r);
            end
        end else begin
            s_q <= s_d;
        end
    end

    // dispatch and register read
    always_comb begin
        disp_valid = rdy_found;
        disp_tag   = rdy_found ? (TAG_W'(rdy_idx) + TAG_W'(1)) : '0;
        disp_op    = s_q.ent[rdy_idx].op;
        disp_a     = s_q.ent[rdy_idx].vj;
        disp_b     = s_q.ent[rdy_idx].vk;
        rf_data    = s_q.rf[rf_addr];
        rf_pend    = s_q.stat[rf_addr];
    end
endmodule

// File: rtl/rs_rename_core_chk.sv
module rs_rename_core_chk #(
    parameter int DATA_W   = 64,
    parameter int TAG_W    = 4,
    parameter int NUM_ADD  = 3,
    parameter int NUM_MUL  = 2,
    parameter int REG_AW   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic              iss_cls,
    input logic [REG_AW-1:0] iss_rd,
    input logic              iss_stall,
    input logic [TAG_W-1:0]  iss_tag,
    input logic              disp_valid,
    input logic [TAG_W-1:0]  disp_tag,
    input logic              res_valid,
    input logic [TAG_W-1:0]  res_tag,
    input logic [DATA_W-1:0] res_data,
    input logic [REG_AW-1:0] rf_addr,
    input logic [DATA_W-1:0] rf_data,
    input logic [TAG_W-1:0]  rf_pend
);
    localparam int NUM_RS = NUM_ADD + NUM_MUL;

    assert_stall_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_stall |-> iss_valid);

    assert_tag_in_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_stall) |->
            ((iss_cls == 1'b0) ? (iss_tag >= TAG_W'(1) && iss_tag <= TAG_W'(NUM_ADD))
                               : (iss_tag > TAG_W'(NUM_ADD) && iss_tag <= TAG_W'(NUM_RS))));

    assert_disp_tag_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_tag != '0 && disp_tag <= TAG_W'(NUM_RS)));

    assert_no_redispatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !(disp_valid && disp_tag == $past(disp_tag)));

    assert_rename_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_stall && iss_rd == rf_addr) |=>
            (($past(rf_addr) != rf_addr) || (rf_pend == $past(iss_tag))));

    assert_regfile_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && rf_pend != '0 && rf_pend == res_tag &&
         !(iss_valid && !iss_stall && iss_rd == rf_addr)) |=>
            (($past(rf_addr) != rf_addr) ||
             (rf_pend == '0 && rf_data == $past(res_data))));
endmodule

bind rs_rename_core rs_rename_core_chk #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .NUM_ADD(NUM_ADD), .NUM_MUL(NUM_MUL),
    .REG_AW($clog2(NUM_REGS))
) i_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cls(iss_cls),
    .iss_rd(iss_rd), .iss_stall(iss_stall), .iss_tag(iss_tag),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .res_valid(res_valid),
    .res_tag(res_tag), .res_data(res_data), .rf_addr(rf_addr),
    .rf_data(rf_data), .rf_pend(rf_pend)
);

// File: tb/test_rs_rename_core.sv
`timescale 1ns/1ps
module test_rs_rename_core;
    localparam int NA = 3;

    typedef struct packed {
        logic        cls;
        logic [2:0]  op;
        logic [2:0]  rd;
        logic [2:0]  rs;
        logic [2:0]  rt;
        logic [63:0] res;
    } row_t;

    localparam row_t TBL [6] = '{
        '{1'b0, 3'd1, 3'd1, 3'd2, 3'd3, 64'h1111_0000_0000_0001},
        '{1'b1, 3'd2, 3'd2, 3'd1, 3'd4, 64'h2222_0000_0000_0002},
        '{1'b0, 3'd3, 3'd3, 3'd3, 3'd3, 64'h3333_0000_0000_0003},
        '{1'b1, 3'd4, 3'd4, 3'd2, 3'd3, 64'h4444_0000_0000_0004},
        '{1'b0, 3'd5, 3'd0, 3'd4, 3'd1, 64'h5555_0000_0000_0005},
        '{1'b1, 3'd6, 3'd5, 3'd5, 3'd0, 64'h6666_0000_0000_0006}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0, iss_cls = 1'b0;
    logic [2:0]  iss_op = '0, iss_rd = '0, iss_rs = '0, iss_rt = '0;
    logic        iss_stall;
    logic [3:0]  iss_tag;
    logic        disp_valid;
    logic [3:0]  disp_tag;
    logic [2:0]  disp_op;
    logic [63:0] disp_a, disp_b;
    logic        res_valid = 1'b0;
    logic [3:0]  res_tag = '0;
    logic [63:0] res_data = '0;
    logic [2:0]  rf_addr = '0;
    logic [63:0] rf_data;
    logic [3:0]  rf_pend;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [63:0] model [8];

    always #2.5 clk = ~clk;

    rs_rename_core i_rs_rename_core (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cls(iss_cls),
        .iss_op(iss_op), .iss_rd(iss_rd), .iss_rs(iss_rs), .iss_rt(iss_rt),
        .iss_stall(iss_stall), .iss_tag(iss_tag), .disp_valid(disp_valid),
        .disp_tag(disp_tag), .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .rf_addr(rf_addr), .rf_data(rf_data), .rf_pend(rf_pend)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        iss_valid = 1'b0;
        res_valid = 1'b0;
    endtask

    task automatic iss(input logic cls, input logic [2:0] op, input logic [2:0] rd,
                       input logic [2:0] rs, input logic [2:0] rt);
        iss_valid = 1'b1; iss_cls = cls; iss_op = op;
        iss_rd = rd; iss_rs = rs; iss_rt = rt;
        #0.1;
    endtask

    task automatic bcast(input logic [3:0] tag, input logic [63:0] data);
        res_valid = 1'b1; res_tag = tag; res_data = data;
        #0.1;
    endtask

    task automatic peek(input logic [2:0] r);
        rf_addr = r;
        #0.1;
    endtask

    initial begin
        #100us;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 8; r++) model[r] = 64'(r);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        // R1: reset state
        chk("R1 disp_valid", 64'(disp_valid), 64'd0);
        for (int r = 0; r < 8; r++) begin
            peek(3'(r));
            chk("R1 reg value", rf_data, 64'(r));
            chk("R1 reg pending", 64'(rf_pend), 64'd0);
        end

        // table walk: issue, dispatch, broadcast, register update
        for (int k = 0; k < 6; k++) begin
            iss(TBL[k].cls, TBL[k].op, TBL[k].rd, TBL[k].rs, TBL[k].rt);
            chk("R7 no stall", 64'(iss_stall), 64'd0);
            chk("R7/R8 tag", 64'(iss_tag), TBL[k].cls ? 64'(NA + 1) : 64'd1);
            step();
            chk("R6 dispatch valid", 64'(disp_valid), 64'd1);
            chk("R6 dispatch tag", 64'(disp_tag), TBL[k].cls ? 64'(NA + 1) : 64'd1);
            chk("R2 op", 64'(disp_op), 64'(TBL[k].op));
            chk("R2/R11 operand a", disp_a, model[TBL[k].rs]);
            chk("R2/R11 operand b", disp_b, model[TBL[k].rt]);
            step();
            bcast(TBL[k].cls ? 4'(NA + 1) : 4'd1, TBL[k].res);
            step();
            model[TBL[k].rd] = TBL[k].res;
            peek(TBL[k].rd);
            chk("R5 reg written", rf_data, TBL[k].res);
            chk("R5 pending cleared", 64'(rf_pend), 64'd0);
        end

        // R3/R4: waiting on a producer, both operands captured
        iss(1'b1, 3'd1, 3'd1, 3'd2, 3'd3);
        step();
        chk("R2 mul dispatch tag", 64'(disp_tag), 64'(NA + 1));
        chk("R2 mul operand a", disp_a, model[2]);
        iss(1'b0, 3'd2, 3'd5, 3'd1, 3'd1);
        chk("R7 add tag", 64'(iss_tag), 64'd1);
        step();
        chk("R3 waiting not dispatched", 64'(disp_valid), 64'd0);
        peek(3'd1);
        chk("R3 pending tag", 64'(rf_pend), 64'(NA + 1));
        step();
        chk("R3 still waiting", 64'(disp_valid), 64'd0);
        bcast(4'(NA + 1), 64'hABCD_0000_1234_5678);
        step();
        model[1] = 64'hABCD_0000_1234_5678;
        chk("R4 dispatch after capture", 64'(disp_tag), 64'd1);
        chk("R4 operand a captured", disp_a, model[1]);
        chk("R4 operand b captured", disp_b, model[1]);
        chk("R5 reg from bus", rf_data, model[1]);
        bcast(4'd1, 64'h5);
        step();
        model[5] = 64'h5;

        // R5: write-after-write, older result must not reach the register
        iss(1'b0, 3'd0, 3'd6, 3'd0, 3'd0);
        step();
        iss(1'b0, 3'd0, 3'd6, 3'd0, 3'd0);
        chk("R7 second add tag", 64'(iss_tag), 64'd2);
        step();
        peek(3'd6);
        chk("R5 renamed to newest", 64'(rf_pend), 64'd2);
        step();
        bcast(4'd1, 64'hDEAD);
        step();
        chk("R5 old result ignored pend", 64'(rf_pend), 64'd2);
        chk("R5 old result ignored value", rf_data, model[6]);
        bcast(4'd2, 64'hBEEF);
        step();
        model[6] = 64'hBEEF;
        chk("R5 newest result written", rf_data, 64'hBEEF);

        // R10: write-after-read, captured value survives a younger writer
        iss(1'b1, 3'd3, 3'd3, 3'd4, 3'd4);
        step();
        iss(1'b0, 3'd4, 3'd0, 3'd3, 3'd7);
        step();
        iss(1'b0, 3'd5, 3'd7, 3'd6, 3'd6);
        step();
        chk("R6 younger writer dispatched", 64'(disp_tag), 64'd2);
        step();
        bcast(4'd2, 64'h7777);
        step();
        bcast(4'(NA + 1), 64'h3030);
        step();
        chk("R10 reader dispatched", 64'(disp_tag), 64'd1);
        chk("R10 operand a from bus", disp_a, 64'h3030);
        chk("R10 operand b old value", disp_b, model[7]);
        model[7] = 64'h7777;
        model[3] = 64'h3030;
        bcast(4'd1, 64'h0);
        step();
        model[0] = 64'h0;

        // R9: broadcast and issue in the same cycle
        iss(1'b1, 3'd1, 3'd3, 3'd1, 3'd1);
        step();
        step();
        iss(1'b0, 3'd2, 3'd0, 3'd3, 3'd3);
        bcast(4'(NA + 1), 64'h9999);
        step();
        chk("R9 dispatched at once", 64'(disp_tag), 64'd1);
        chk("R9 bypass a", disp_a, 64'h9999);
        chk("R9 bypass b", disp_b, 64'h9999);
        bcast(4'd1, 64'h1);
        step();

        // R7/R8: class full stalls, freed station reused
        iss(1'b0, 3'd1, 3'd1, 3'd2, 3'd2);
        step();
        iss(1'b0, 3'd1, 3'd2, 3'd2, 3'd2);
        step();
        iss(1'b0, 3'd1, 3'd4, 3'd2, 3'd2);
        chk("R7 third add tag", 64'(iss_tag), 64'd3);
        step();
        iss(1'b0, 3'd1, 3'd5, 3'd2, 3'd2);
        chk("R7 adder full stalls", 64'(iss_stall), 64'd1);
        chk("R7 no tag on stall", 64'(iss_tag), 64'd0);
        iss(1'b1, 3'd6, 3'd6, 3'd2, 3'd2);
        chk("R7 multiplier still free", 64'(iss_stall), 64'd0);
        chk("R7 multiplier tag", 64'(iss_tag), 64'(NA + 1));
        step();
        bcast(4'd2, 64'h22);
        step();
        iss(1'b0, 3'd7, 3'd5, 3'd2, 3'd2);
        chk("R8 freed tag reused", 64'(iss_tag), 64'd2);
        step();
        chk("R8 reused station dispatched", 64'(disp_tag), 64'd2);
        chk("R8 reused op", 64'(disp_op), 64'd7);
        step();
        bcast(4'd1, 64'h1); step();
        bcast(4'd3, 64'h3); step();
        bcast(4'(NA + 1), 64'h4); step();
        bcast(4'd2, 64'h5); step();
        chk("R6 all drained", 64'(disp_valid), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule